// File: doc/BRIEF.md
# Stored-Program Register Machine

This block is a very small sequential processor. It has four 16-bit user registers, a program counter and a one-bit carry flag. Program and data share one memory. For each instruction the machine reads the word at the program counter, moves the counter forward by one, and then carries out the instruction. An instruction that needs an immediate value or a jump target finds it in the next memory word, and the counter also steps past that word.

The instruction set is kept small. It has seven operations:

- load a constant
- add two registers
- copy a register
- subtract a register from a constant, which also records a borrow in carry
- jump when carry is set
- jump always
- halt

This set is enough to run a loop that builds Fibonacci numbers until a limit is passed.

Memory is filled through a write port while reset is held. After reset is released the machine runs until it reaches a halt. The four registers can be read at any time through a selectable readout.

Top module: `tinyrm_top`

## Requirements
- R1: While reset is high at a clock edge, all four registers, the program counter and carry become zero and halted goes low. After reset is released, the first fetch is from address 0.
- R2: Each instruction takes exactly two clocks, one to fetch and one to execute. The fetch loads the word at the program counter and adds one to the counter. An instruction that carries an immediate takes it from the following word and adds one to the counter again, unless it jumps.
- R3: Opcode 1 (bits 15:12) loads the immediate into the destination register. The destination field is bits 7:6, where field value 0 to 3 selects R1 to R4.
- R4: Opcode 2 writes the sum of the register in bits 11:10 and the register in bits 9:8 to the destination, modulo 2^16. Carry does not change.
- R5: Opcode 3 copies the register in bits 11:10 into the destination register.
- R6: Opcode 4 writes the immediate minus the register in bits 11:10 to the destination, modulo 2^16. It sets carry when that register is greater than the immediate and clears carry otherwise, so equal values clear it. No other instruction changes carry.
- R7: Opcode 5 loads the program counter with the low 8 bits of the immediate when carry is set. Otherwise execution continues after the immediate word.
- R8: Opcode 6 always loads the program counter with the low 8 bits of the immediate.
- R9: Opcode 0 halts the machine. Halted rises on the clock edge after its execute cycle. From then on, registers, carry and program counter hold until the next reset, even if memory is written.
- R10: Opcodes 7 to 15 change no register and no flag. They only advance to the next word.
- R11: The Fibonacci loop stops once a new term exceeds 1000. It ends with R1=987, R2=1597, R3=1597 and R4=64939 (1000-1597 modulo 2^16).
- R12: The readout shows register R1 to R4 for regSel 0 to 3, with no clock delay. Bits 5:0 of an instruction word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memWe | input | 1 | Memory write strobe |
| memAddr | input | 8 | Memory write address |
| memWdata | input | 16 | Memory write data |
| regSel | input | 2 | Readout select, 0..3 for R1..R4 |
| regOut | output | 16 | Selected register value |
| halted | output | 1 | High once a halt has executed |

## Verification
The machine is tried with several kinds of program:

- Directed programs push each operation to its edge: addition that wraps past 2^16, subtraction with equal operands so carry stays clear, carry that survives an intervening add, a jump over dead code, and words carrying the unused opcodes.
- Random straight-line programs use random register fields and random spare bits, plus taken and untaken forward conditional jumps. They tell apart decode faults in source and destination selection, and show whether the spare bits are ignored.
- The Fibonacci loop exercises backward jumps and many carry updates.

The number of clocks to halt is compared with twice the instruction count, which exposes any extra or missing cycle in fetch or execute. A memory write after halt shows whether the frozen state really holds.

// File: rtl/tinyrm_pkg.sv
package tinyrm_pkg;

  localparam int NREG    = 4;
  localparam int OPC_LSB = 12;
  localparam int SRCA_LSB = 10;
  localparam int SRCB_LSB = 8;
  localparam int DST_LSB  = 6;
  localparam int IR_W     = OPC_LSB + 4 - DST_LSB;

  localparam logic [3:0] OP_HALT = 4'd0;
  localparam logic [3:0] OP_LDI  = 4'd1;
  localparam logic [3:0] OP_ADD  = 4'd2;
  localparam logic [3:0] OP_MOV  = 4'd3;
  localparam logic [3:0] OP_SUBI = 4'd4;
  localparam logic [3:0] OP_JC   = 4'd5;
  localparam logic [3:0] OP_JMP  = 4'd6;

  typedef enum logic [1:0] {WB_IMM, WB_ADD, WB_MOV, WB_SUB} wbsel_e;

  typedef struct packed {
    logic   irLoad;
    logic   pcInc;
    logic   pcLoad;
    logic   regWe;
    logic   carryWe;
    wbsel_e wbSel;
  } strobes_t;

endpackage

// File: rtl/tinyrm_mem.sv
module tinyrm_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wAddr] <= wData;
  end

  assign rData = store[rAddr];
endmodule

// File: rtl/tinyrm_ctrl.sv
module tinyrm_ctrl
  import tinyrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  input  logic       carry,
  output strobes_t   strb,
  output logic       halted
);
  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_STOP} state_e;
  state_e stateQ, stateD;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    case (stateQ)
      S_FETCH: begin
        strb.irLoad = 1'b1;
        strb.pcInc  = 1'b1;
        stateD      = S_EXEC;
      end
      S_EXEC: begin
        stateD = S_FETCH;
        case (opcode)
          OP_HALT: stateD = S_STOP;
          OP_LDI: begin
            strb.regWe = 1'b1;
            strb.wbSel = WB_IMM;
            strb.pcInc = 1'b1;
          end
          OP_ADD: begin
            strb.regWe = 1'b1;
            strb.wbSel = WB_ADD;
          end
          OP_MOV: begin
            strb.regWe = 1'b1;
            strb.wbSel = WB_MOV;
          end
          OP_SUBI: begin
            strb.regWe   = 1'b1;
            strb.wbSel   = WB_SUB;
            strb.carryWe = 1'b1;
            strb.pcInc   = 1'b1;
          end
          OP_JC: begin
            strb.pcLoad = carry;
            strb.pcInc  = !carry;
          end
          OP_JMP:  strb.pcLoad = 1'b1;
          default: ;
        endcase
      end
      default: stateD = S_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= S_FETCH;
    else     stateQ <= stateD;
  end

  assign halted = (stateQ == S_STOP);
endmodule

// File: rtl/tinyrm_datapath.sv
module tinyrm_datapath
  import tinyrm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [1:0]        regSel,
  output logic [ADDR_W-1:0] pc,
  output logic [3:0]        opcode,
  output logic              carry,
  output logic [DATA_W-1:0] regOut
);
  logic [IR_W-1:0]   irQ;
  logic [DATA_W-1:0] rf [NREG];
  logic [1:0]        srcA, srcB, dst;
  logic [DATA_W-1:0] aVal, bVal, wbVal;
  logic [DATA_W:0]   subExt;

  assign opcode = irQ[OPC_LSB-DST_LSB +: 4];
  assign srcA   = irQ[SRCA_LSB-DST_LSB +: 2];
  assign srcB   = irQ[SRCB_LSB-DST_LSB +: 2];
  assign dst    = irQ[1:0];
  assign aVal   = rf[srcA];
  assign bVal   = rf[srcB];
  assign subExt = {1'b0, memRdata} - {1'b0, aVal};

  always_comb begin
    case (strb.wbSel)
      WB_IMM:  wbVal = memRdata;
      WB_ADD:  wbVal = aVal + bVal;
      WB_MOV:  wbVal = aVal;
      default: wbVal = subExt[DATA_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irQ   <= '0;
      pc    <= '0;
      carry <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (strb.irLoad)  irQ <= memRdata[OPC_LSB+3:DST_LSB];
      if (strb.pcLoad)  pc <= memRdata[ADDR_W-1:0];
      else if (strb.pcInc) pc <= pc + 1'b1;
      if (strb.carryWe) carry <= subExt[DATA_W];
      if (strb.regWe)   rf[dst] <= wbVal;
    end
  end

  assign regOut = rf[regSel];
endmodule

// File: rtl/tinyrm_top.sv
module tinyrm_top
  import tinyrm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  input  logic [1:0]        regSel,
  output logic [DATA_W-1:0] regOut,
  output logic              halted
);
  strobes_t          strbW;
  logic [ADDR_W-1:0] pcW;
  logic [DATA_W-1:0] rdataW;
  logic [3:0]        opcodeW;
  logic              carryW;

  tinyrm_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .we(memWe), .wAddr(memAddr), .wData(memWdata),
    .rAddr(pcW), .rData(rdataW)
  );

  tinyrm_ctrl ctrl_i (
    .clk(clk), .rst(rst), .opcode(opcodeW), .carry(carryW),
    .strb(strbW), .halted(halted)
  );

  tinyrm_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strbW), .memRdata(rdataW),
    .regSel(regSel), .pc(pcW), .opcode(opcodeW), .carry(carryW),
    .regOut(regOut)
  );
endmodule

// File: rtl/tinyrm_chk.sv
module tinyrm_chk
  import tinyrm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic [ADDR_W-1:0] pc,
  input logic              carry,
  input strobes_t          strb
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && !carry && !halted));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(carry)));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !(strb.regWe || strb.pcInc || strb.pcLoad || strb.carryWe || strb.irLoad));

  // R6
  carry_owner_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.carryWe |=> $stable(carry));

  // R7
  pc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.pcInc, strb.pcLoad}));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.pcInc && !strb.pcLoad) |=> (pc == ADDR_W'($past(pc) + 1'b1)));
endmodule

bind tinyrm_top tinyrm_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .halted(halted), .pc(pcW), .carry(carryW), .strb(strbW)
);

// File: tb/tinyrm_tb.sv
module tinyrm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        memWe = 1'b0;
  logic [7:0]  memAddr = '0;
  logic [15:0] memWdata = '0;
  logic [1:0]  regSel = '0;
  logic [15:0] regOut;
  logic        halted;

  int checks = 0;
  int errors = 0;

  logic [15:0] tbMem [256];
  int          progLen;
  logic [15:0] mR [4];
  logic        mC;
  int          mSteps;
  int          lastCyc;

  always #4 clk = ~clk;

  tinyrm_top dut_i (
    .clk(clk), .rst(rst), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .regSel(regSel), .regOut(regOut), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [1:0] a,
                                      input logic [1:0] b, input logic [1:0] d,
                                      input logic [5:0] spare);
    return {op, a, b, d, spare};
  endfunction

  task automatic put(input logic [15:0] w);
    tbMem[progLen] = w;
    progLen++;
  endtask

  // Independent interpreter built from the requirements.
  task automatic model();
    logic [7:0]  p = '0;
    logic [15:0] w, imm;
    logic [1:0]  a, b, d;
    for (int k = 0; k < 4; k++) mR[k] = '0;
    mC = 1'b0;
    mSteps = 0;
    for (int n = 0; n < 1000; n++) begin
      w = tbMem[p]; p++; mSteps++;
      a = w[11:10]; b = w[9:8]; d = w[7:6];
      if (w[15:12] == 4'd0) break;
      case (w[15:12])
        4'd1: begin mR[d] = tbMem[p]; p++; end
        4'd2: mR[d] = mR[a] + mR[b];
        4'd3: mR[d] = mR[a];
        4'd4: begin imm = tbMem[p]; p++; mC = (mR[a] > imm); mR[d] = imm - mR[a]; end
        4'd5: begin imm = tbMem[p]; p++; if (mC) p = imm[7:0]; end
        4'd6: begin imm = tbMem[p]; p = imm[7:0]; end
        default: ;
      endcase
    end
  endtask

  task automatic run_prog(input string tag);
    int cyc = 0;
    model();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < progLen; i++) begin
      @(negedge clk);
      memWe = 1'b1; memAddr = 8'(i); memWdata = tbMem[i];
    end
    @(negedge clk);
    memWe = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    while (!halted && cyc < 3000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    lastCyc = cyc;
    chk(cyc == 2 * mSteps, {"R2 clocks to halt ", tag}, cyc, 2 * mSteps);
    for (int k = 0; k < 4; k++) begin
      regSel = 2'(k); #1;
      chk(regOut == mR[k], {"R12 register readout ", tag}, regOut, mR[k]);
    end
  endtask

  task automatic reg_is(input int k, input logic [15:0] v, input string req);
    regSel = 2'(k); #1;
    chk(regOut == v, req, regOut, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(halted == 1'b0, "R1 halted low in reset", halted, 0);
    for (int k = 0; k < 4; k++) reg_is(k, 16'h0, "R1 register zero after reset");

    // R3 R4: add wraps
    progLen = 0;
    put(enc(4'd1, 0, 0, 0, 0)); put(16'hFFFF);
    put(enc(4'd1, 0, 0, 1, 6'h2A)); put(16'h0002);
    put(enc(4'd2, 0, 1, 2, 6'h15));
    put(enc(4'd1, 0, 0, 3, 0)); put(16'h1234);
    put(16'h0000);
    run_prog("add wrap");
    reg_is(2, 16'h0001, "R4 sum wraps modulo 2^16");
    reg_is(3, 16'h1234, "R3 load immediate");

    // R4 R6 R7: carry survives an add, taken jump
    progLen = 0;
    put(enc(4'd1, 0, 0, 0, 0)); put(16'd5);
    put(enc(4'd4, 0, 0, 3, 0)); put(16'd3);
    put(enc(4'd2, 0, 0, 2, 0));
    put(enc(4'd5, 0, 0, 0, 0)); put(16'd9);
    put(enc(4'd1, 0, 0, 1, 0)); put(16'h0BAD);
    put(enc(4'd1, 0, 0, 1, 0)); put(16'h0077);
    put(16'h0000);
    run_prog("carry kept");
    reg_is(1, 16'h0077, "R7 taken jump on carry left by subtract (R4 keeps carry)");
    reg_is(3, 16'hFFFE, "R6 subtract borrows");

    // R6 R7: equal operands clear carry, jump not taken
    progLen = 0;
    put(enc(4'd1, 0, 0, 0, 0)); put(16'd7);
    put(enc(4'd4, 0, 0, 1, 0)); put(16'd7);
    put(enc(4'd5, 0, 0, 0, 0)); put(16'd8);
    put(enc(4'd1, 0, 0, 2, 0)); put(16'h0055);
    put(16'h0000);
    run_prog("equal subtract");
    reg_is(1, 16'h0000, "R6 equal operands give zero");
    reg_is(2, 16'h0055, "R7 untaken jump falls through");

    // R10: unused opcodes
    progLen = 0;
    put(enc(4'd1, 0, 0, 0, 0)); put(16'h0042);
    for (int op = 7; op < 16; op++) put(enc(4'(op), 2'(op), 2'(op + 1), 2'(op + 2), 6'h3F));
    put(enc(4'd3, 0, 0, 1, 0));
    put(16'h0000);
    run_prog("unused opcodes");
    reg_is(1, 16'h0042, "R10 unused opcodes have no effect");
    chk(lastCyc == 2 * 12, "R10 unused opcodes take one step each", lastCyc, 24);

    // R8: unconditional jump
    progLen = 0;
    put(enc(4'd6, 0, 0, 0, 0)); put(16'd4);
    put(enc(4'd1, 0, 0, 0, 0)); put(16'hDEAD);
    put(enc(4'd1, 0, 0, 1, 0)); put(16'hBEEF);
    put(16'h0000);
    run_prog("jump");
    reg_is(0, 16'h0000, "R8 skipped code not executed");
    reg_is(1, 16'hBEEF, "R8 jump target reached");

    // R11: Fibonacci reference loop
    progLen = 0;
    put(enc(4'd1, 0, 0, 1, 0)); put(16'd1);
    put(enc(4'd2, 0, 1, 2, 0));
    put(enc(4'd3, 1, 0, 0, 0));
    put(enc(4'd3, 2, 0, 1, 0));
    put(enc(4'd4, 2, 0, 3, 0)); put(16'd1000);
    put(enc(4'd5, 0, 0, 0, 0)); put(16'd11);
    put(enc(4'd6, 0, 0, 0, 0)); put(16'd2);
    put(16'h0000);
    run_prog("fibonacci");
    reg_is(0, 16'd987,   "R11 fibonacci R1");
    reg_is(1, 16'd1597,  "R11 fibonacci R2");
    reg_is(2, 16'd1597,  "R11 fibonacci R3");
    reg_is(3, 16'd64939, "R11 fibonacci R4");

    // R9: halted state frozen, memory writes ignored
    @(negedge clk);
    memWe = 1'b1; memAddr = 8'd11; memWdata = enc(4'd1, 0, 0, 0, 0);
    @(negedge clk);
    memAddr = 8'd12; memWdata = 16'h0001;
    @(negedge clk);
    memWe = 1'b0;
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R9 halted stays high", halted, 1);
    reg_is(0, 16'd987, "R9 registers hold after halt");

    // Random straight-line programs with forward conditional jumps
    for (int t = 0; t < 20; t++) begin
      int n = 3 + int'($urandom_range(0, 10));
      progLen = 0;
      for (int i = 0; i < n; i++) begin
        int kind = int'($urandom_range(0, 5));
        logic [1:0] a = 2'($urandom), b = 2'($urandom), d = 2'($urandom);
        logic [5:0] sp = 6'($urandom);
        case (kind)
          0: begin put(enc(4'd1, a, b, d, sp)); put(16'($urandom)); end
          1: put(enc(4'd2, a, b, d, sp));
          2: put(enc(4'd3, a, b, d, sp));
          3: begin put(enc(4'd4, a, b, d, sp)); put(16'($urandom_range(0, 65535))); end
          4: begin
            put(enc(4'd5, a, b, d, sp)); put(16'(progLen + 3));
            put(enc(4'd1, a, b, d, sp)); put(16'($urandom));
          end
          default: put(enc(4'(7 + $urandom_range(0, 8)), a, b, d, sp));
        endcase
      end
      put(16'h0000);
      run_prog("random R3 R4 R5 R6 R7");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule